// File: doc/BRIEF.md
# Fiber Mode Select and Far-End-Fault Controller

This block chooses between copper and fiber operation of a 100 Mb/s line port and handles far-end-fault signalling while in fiber mode. A single analog pin carries both the mode strap and the optical module's signal-detect level. Two comparators outside this block reduce that pin to two digital flags: one above a low threshold and one above a high threshold. The block decodes those flags into three operating states. While the pin sits between the two thresholds, the fiber receiver has no light. In that case the block replaces the outgoing bit stream with a repeating fault pattern, which tells the far end that its transmit path is broken. The pattern is a run of `ONES_LEN` ones followed by a single zero.

The block also watches the received bit stream for the same pattern. After `DET_COUNT` back-to-back complete patterns it raises a received-fault flag. That flag pulls the fiber link indication down even while light is present. The transmitter is left alone and keeps sending the normal stream. While fiber mode is active, the block also drives an inhibit to the auto-negotiation and auto-crossover logic. Every output is updated once per clock, and each clock carries one transmit bit.

The mode state machine has three states. `MODE_COPPER` is the reset state and is used while the low flag is clear. `MODE_FX_NOSIG` is used when the low flag is set and the high flag is clear. `MODE_FX_LINK` is used when both flags are set. Every state can move directly to every other state. The transitions are:
- copper-to-dark
- copper-to-lit
- dark-to-lit
- lit-to-dark
- dark-to-copper
- lit-to-copper

On each clock the state machine loads the state that the current flags decode to. Its outputs follow one clock after the flags.

Top module: `fx_fef_ctrl`

## Requirements
- R1: While reset is held, and in `MODE_COPPER`, `fiber_mode_o`, `an_inhibit_o`, `link_up_o` and `fef_rx_o` are all 0, and `tx_bit_o` equals `tx_bit_i`.
- R2: One clock after `lvl_lo_i`=1 and `lvl_hi_i`=0 are sampled, the block is in `MODE_FX_NOSIG`. In that state `fiber_mode_o`=1 and `link_up_o`=0. With `fef_en_i`=1 the fault pattern is sent on `tx_bit_o`.
- R3: One clock after `lvl_lo_i`=1 and `lvl_hi_i`=1 are sampled, the block is in `MODE_FX_LINK`. In that state `fiber_mode_o`=1, `tx_bit_o` equals `tx_bit_i`, and `link_up_o`=1 whenever `fef_rx_o`=0.
- R4: The sent pattern repeats with period `ONES_LEN`+1: `ONES_LEN` ones, then one zero. Its first bit, a one, goes out in the first cycle of `MODE_FX_NOSIG`.
- R5: `an_inhibit_o` equals `fiber_mode_o` in every cycle.
- R6: In `MODE_FX_LINK`, `link_up_o` is 0 while `fef_rx_o` is 1.
- R7: A received fault does not alter the transmitter: `tx_bit_o` keeps following `tx_bit_i` in `MODE_FX_LINK`.
- R8: With `fef_en_i`=0, `tx_bit_o` follows `tx_bit_i` in `MODE_FX_NOSIG`.
- R9: A received bit is taken only when `rx_vld_i`=1. `fef_rx_o` rises in the clock after the zero that closes the `DET_COUNT`-th consecutive complete pattern (`ONES_LEN` ones, then a zero). Cycles with `rx_vld_i`=0 leave the fault and the pattern tracking unchanged.
- R10: `fef_rx_o` falls in the clock after any of these events:
  - a zero arrives after fewer than `ONES_LEN` ones;
  - a one arrives as the (`ONES_LEN`+1)-th consecutive one;
  - a clock passes in `MODE_COPPER`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_lo_i | input | 1 | Mode pin is above the low threshold |
| lvl_hi_i | input | 1 | Mode pin is above the high (signal-detect) threshold |
| fef_en_i | input | 1 | Fault-pattern generation enable strap |
| rx_bit_i | input | 1 | Received bit |
| rx_vld_i | input | 1 | Received bit is valid this cycle |
| tx_bit_i | input | 1 | Normal transmit bit |
| fiber_mode_o | output | 1 | Fiber operation selected |
| an_inhibit_o | output | 1 | Disable auto-negotiation and auto-crossover |
| tx_bit_o | output | 1 | Outgoing bit: normal data or fault pattern |
| fef_rx_o | output | 1 | Far-end fault is being received |
| link_up_o | output | 1 | Fiber link is up |

## Verification
The assertions take for granted that the two level flags are consistent. The high flag is never set while the low flag is clear, because the comparator thresholds are ordered. The bench keeps to this by driving only the three legal flag combinations. The receive checks assume the pattern starts aligned after reset or after a zero, and the stimulus always begins a new pattern at such a point. Gaps with `rx_vld_i` low are inserted only between whole bits, so no half-formed bit ever reaches the detector.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
    typedef enum logic [1:0] {
        MODE_COPPER   = 2'd0,
        MODE_FX_NOSIG = 2'd1,
        MODE_FX_LINK  = 2'd2
    } fx_mode_e;
endpackage

// File: rtl/fx_mode_fsm.sv
module fx_mode_fsm
    import fxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_lo_i,
    input  logic lvl_hi_i,
    output logic fiber_o,
    output logic nosig_o,
    output logic lit_o
);
    fx_mode_e state_q, state_d, decoded;

    // Pin level decode: the low flag alone selects dark fiber, both select lit fiber.
    always_comb begin
        if (!lvl_lo_i)     decoded = MODE_COPPER;
        else if (lvl_hi_i) decoded = MODE_FX_LINK;
        else               decoded = MODE_FX_NOSIG;
    end

    // Named transitions; all go directly to the decoded state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_COPPER: begin
                if (decoded == MODE_FX_NOSIG)     state_d = MODE_FX_NOSIG; // copper-to-dark
                else if (decoded == MODE_FX_LINK) state_d = MODE_FX_LINK;  // copper-to-lit
            end
            MODE_FX_NOSIG: begin
                if (decoded == MODE_FX_LINK)      state_d = MODE_FX_LINK;  // dark-to-lit
                else if (decoded == MODE_COPPER)  state_d = MODE_COPPER;   // dark-to-copper
            end
            MODE_FX_LINK: begin
                if (decoded == MODE_FX_NOSIG)     state_d = MODE_FX_NOSIG; // lit-to-dark
                else if (decoded == MODE_COPPER)  state_d = MODE_COPPER;   // lit-to-copper
            end
            default: state_d = MODE_COPPER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_COPPER;
        else        state_q <= state_d;
    end

    always_comb begin
        fiber_o = 1'b0;
        nosig_o = 1'b0;
        lit_o   = 1'b0;
        unique case (state_q)
            MODE_COPPER:   ;
            MODE_FX_NOSIG: begin fiber_o = 1'b1; nosig_o = 1'b1; end
            MODE_FX_LINK:  begin fiber_o = 1'b1; lit_o   = 1'b1; end
            default:       ;
        endcase
    end

    AST_FIBER_NEEDS_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_o |-> $past(lvl_lo_i)); // R2
    AST_LIT_NEEDS_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        lit_o |-> $past(lvl_hi_i)); // R3
endmodule

// File: rtl/fef_tx_gen.sv
module fef_tx_gen #(
    parameter int ONES_LEN = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nosig_i,
    input  logic fef_en_i,
    input  logic tx_bit_i,
    output logic tx_bit_o
);
    localparam int CW = $clog2(ONES_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(ONES_LEN);

    logic [CW-1:0] pos_q;
    logic          pat_bit;
    logic          gen_on;

    always_ff @(posedge clk) begin
        if (!rst_n || !nosig_i) pos_q <= '0;
        else if (pos_q == LAST)  pos_q <= '0;
        else                     pos_q <= pos_q + 1'b1;
    end

    assign pat_bit  = (pos_q != LAST);
    assign gen_on   = nosig_i && fef_en_i;
    assign tx_bit_o = gen_on ? pat_bit : tx_bit_i;

    AST_PATTERN_STARTS_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nosig_i) |-> pat_bit); // R4
    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_on && !tx_bit_o) |=> (!nosig_i || tx_bit_o || !fef_en_i)); // R4
endmodule

// File: rtl/fef_rx_det.sv
module fef_rx_det #(
    parameter int ONES_LEN  = 84,
    parameter int DET_COUNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    output logic fault_o
);
    localparam int OW = $clog2(ONES_LEN + 2);
    localparam int PW = $clog2(DET_COUNT + 1);
    localparam logic [OW-1:0] RUN_FULL = OW'(ONES_LEN);
    localparam logic [OW-1:0] RUN_OVER = OW'(ONES_LEN + 1);
    localparam logic [PW-1:0] PAT_NEED = PW'(DET_COUNT);

    logic [OW-1:0] run_q;
    logic [PW-1:0] pat_q;
    logic          fault_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            run_q   <= '0;
            pat_q   <= '0;
            fault_q <= 1'b0;
        end else if (rx_vld_i) begin
            if (rx_bit_i) begin
                if (run_q == RUN_FULL) begin
                    run_q   <= RUN_OVER;
                    pat_q   <= '0;
                    fault_q <= 1'b0;
                end else if (run_q != RUN_OVER) begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
                if (run_q == RUN_FULL) begin
                    if (pat_q != PAT_NEED) pat_q <= pat_q + 1'b1;
                    if (pat_q >= PAT_NEED - 1'b1) fault_q <= 1'b1;
                end else begin
                    pat_q   <= '0;
                    fault_q <= 1'b0;
                end
            end
        end
    end

    assign fault_o = fault_q;

    AST_FAULT_RISES_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(rx_vld_i && !rx_bit_i)); // R9
    AST_FAULT_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld_i && !clr_i) |=> $stable(fault_o)); // R9
endmodule

// File: rtl/fx_fef_ctrl.sv
module fx_fef_ctrl #(
    parameter int ONES_LEN  = 84,
    parameter int DET_COUNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_lo_i,
    input  logic lvl_hi_i,
    input  logic fef_en_i,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    input  logic tx_bit_i,
    output logic fiber_mode_o,
    output logic an_inhibit_o,
    output logic tx_bit_o,
    output logic fef_rx_o,
    output logic link_up_o
);
    logic fiber, nosig, lit, fault;

    fx_mode_fsm i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_lo_i (lvl_lo_i),
        .lvl_hi_i (lvl_hi_i),
        .fiber_o  (fiber),
        .nosig_o  (nosig),
        .lit_o    (lit)
    );

    fef_tx_gen #(.ONES_LEN(ONES_LEN)) i_txgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .nosig_i  (nosig),
        .fef_en_i (fef_en_i),
        .tx_bit_i (tx_bit_i),
        .tx_bit_o (tx_bit_o)
    );

    fef_rx_det #(.ONES_LEN(ONES_LEN), .DET_COUNT(DET_COUNT)) i_rxdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (!fiber),
        .rx_bit_i (rx_bit_i),
        .rx_vld_i (rx_vld_i),
        .fault_o  (fault)
    );

    assign fiber_mode_o = fiber;
    assign an_inhibit_o = fiber;
    assign fef_rx_o     = fault;
    assign link_up_o    = lit && !fault;

    AST_LINK_NEEDS_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> $past(lvl_hi_i)); // R3
    AST_FAULT_ONLY_AFTER_FIBER: assert property (@(posedge clk) disable iff (!rst_n)
        fef_rx_o |-> $past(fiber_mode_o)); // R10
    AST_LIT_TX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (fiber_mode_o && $past(lvl_hi_i) && $past(fiber_mode_o)) |-> (tx_bit_o == tx_bit_i)); // R7
endmodule

// File: tb/test_fx_fef_ctrl.sv
module test_fx_fef_ctrl;
    localparam int PERIOD = 10;
    localparam int ONES   = 84;
    localparam int NEED   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl_lo = 1'b0, lvl_hi = 1'b0, fef_en = 1'b1;
    logic rx_bit = 1'b0, rx_vld = 1'b0, tx_in = 1'b0;
    logic fiber_mode, an_inhibit, tx_out, fef_rx, link_up;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    fx_fef_ctrl #(.ONES_LEN(ONES), .DET_COUNT(NEED)) i_fx_fef_ctrl (
        .clk(clk), .rst_n(rst_n), .lvl_lo_i(lvl_lo), .lvl_hi_i(lvl_hi),
        .fef_en_i(fef_en), .rx_bit_i(rx_bit), .rx_vld_i(rx_vld), .tx_bit_i(tx_in),
        .fiber_mode_o(fiber_mode), .an_inhibit_o(an_inhibit), .tx_bit_o(tx_out),
        .fef_rx_o(fef_rx), .link_up_o(link_up)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        rx_vld = 1'b1;
        rx_bit = b;
        tick();
        rx_vld = 1'b0;
    endtask

    task automatic send_ones(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic set_mode(logic lo, logic hi);
        lvl_lo = lo;
        lvl_hi = hi;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs while reset is held
        set_mode(1'b1, 1'b1);
        tx_in = 1'b1;
        repeat (3) tick();
        check("R1", "fiber in reset", fiber_mode, 1'b0);
        check("R1", "link in reset", link_up, 1'b0);
        check("R1", "fault in reset", fef_rx, 1'b0);
        check("R1", "tx in reset", tx_out, 1'b1);
        set_mode(1'b0, 1'b0);
        rst_n = 1'b1;
        tick();

        // Sweep legal level combinations x strap x tx data, entering from copper each time
        for (int m = 0; m < 3; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int d = 0; d < 2; d++) begin
                    logic lo, hi, exp_fib, exp_tx, exp_link;
                    set_mode(1'b0, 1'b0);
                    tick();
                    lo = (m != 0);
                    hi = (m == 2);
                    fef_en = e[0];
                    tx_in = d[0];
                    set_mode(lo, hi);
                    tick();
                    exp_fib  = lo;
                    exp_link = hi;
                    exp_tx   = (m == 1 && e == 1) ? 1'b1 : d[0];
                    check(m == 0 ? "R1" : (m == 1 ? "R2" : "R3"), "fiber_mode", fiber_mode, exp_fib);
                    check("R5", "an_inhibit", an_inhibit, exp_fib);
                    check(m == 1 ? "R2" : "R3", "link_up", link_up, exp_link);
                    check(m == 1 ? (e == 1 ? "R4" : "R8") : "R1", "tx_bit", tx_out, exp_tx);
                    tx_in = ~d[0];
                    #1;
                    exp_tx = (m == 1 && e == 1) ? 1'b1 : ~d[0];
                    check(m == 1 ? (e == 1 ? "R4" : "R8") : "R3", "tx_bit toggled", tx_out, exp_tx);
                end
            end
        end

        // R4: three full periods of the fault pattern from the start of the dark state
        set_mode(1'b0, 1'b0);
        fef_en = 1'b1;
        tick();
        set_mode(1'b1, 1'b0);
        for (int k = 0; k < 3 * (ONES + 1); k++) begin
            tick();
            tx_in = k[0];
            #1;
            check("R4", "pattern bit", tx_out, ((k % (ONES + 1)) != ONES) ? 1'b1 : 1'b0);
        end

        // R8: strap low in the dark state passes data
        fef_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tx_in = k[1];
            tick();
            check("R8", "strap low pass", tx_out, k[1]);
        end
        fef_en = 1'b1;

        // Lit fiber, receive patterns
        set_mode(1'b1, 1'b1);
        tick();
        check("R3", "link up lit", link_up, 1'b1);
        for (int p = 1; p <= NEED; p++) begin
            send_ones(ONES);
            if (p == NEED) begin
                repeat (4) tick(); // idle gap inside the last pattern
                check("R9", "no fault before closing zero", fef_rx, 1'b0);
            end
            send_bit(1'b0);
            check("R9", "fault after pattern", fef_rx, (p >= NEED) ? 1'b1 : 1'b0);
            check("R6", "link vs fault", link_up, (p >= NEED) ? 1'b0 : 1'b1);
        end
        repeat (5) tick();
        check("R9", "fault held over idle", fef_rx, 1'b1);
        tx_in = 1'b0; #1;
        check("R7", "tx untouched 0", tx_out, 1'b0);
        tx_in = 1'b1; #1;
        check("R7", "tx untouched 1", tx_out, 1'b1);
        send_ones(ONES);
        send_bit(1'b0);
        check("R9", "fault continues", fef_rx, 1'b1);

        // R10: early zero breaks
        send_ones(39);
        check("R10", "fault before early zero", fef_rx, 1'b1);
        send_bit(1'b0);
        check("R10", "early zero clears", fef_rx, 1'b0);
        check("R6", "link back", link_up, 1'b1);

        // Rebuild, then too many ones breaks
        for (int p = 0; p < NEED; p++) begin send_ones(ONES); send_bit(1'b0); end
        check("R9", "fault rebuilt", fef_rx, 1'b1);
        send_ones(ONES);
        check("R10", "fault at full run", fef_rx, 1'b1);
        send_bit(1'b1);
        check("R10", "extra one clears", fef_rx, 1'b0);
        send_bit(1'b0);
        check("R10", "zero after overrun no fault", fef_rx, 1'b0);

        // Rebuild, then copper clears
        for (int p = 0; p < NEED; p++) begin send_ones(ONES); send_bit(1'b0); end
        check("R9", "fault rebuilt again", fef_rx, 1'b1);
        set_mode(1'b0, 1'b0);
        tick();
        check("R1", "copper fiber flag", fiber_mode, 1'b0);
        tick();
        check("R10", "copper clears fault", fef_rx, 1'b0);
        set_mode(1'b1, 1'b1);
        tick();
        check("R3", "link after return", link_up, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule